// File: doc/BRIEF.md
# Sector Header Capture Registers

This block picks the identification bytes of each sector out of a CD sector byte stream and holds them in four byte-wide registers that a host processor reads over a simple register bus. In its default source setting it keeps the first four stream bytes after a sector sync, which form the sector header. With subheader selection it keeps four stream bytes taken further into the sector instead. With Q-channel time selection it ignores the sector stream and loads minute, second and frame bytes from the subcode path, each one as soon as it arrives.

An active-low sector-available flag tells software when a complete set of bytes has been captured, so that it can read them before the next sector replaces them. The block also holds an active-low transfer-end flag. A one-cycle completion pulse sets it, and any write to the acknowledge address clears it. An interrupt output follows the flag, gated by an enable bit. Sync detection, error correction, descrambling and subcode demodulation sit outside the block and reach it as byte strobes.

Top module: `hdr_capture`

## Requirements
- R1: After reset the four ID registers read 00h, the status register reads 03h (sector-available bit 0 = 1, transfer-end bit 1 = 1, both inactive), the config register reads 00h and `irq_o` is 0.
- R2: In header source (config bit 0 = 0, bit 1 = 0), stream bytes number 0 to 3 after a sync are stored in ID registers 0 to 3, which are read at addresses 20h to 23h.
- R3: In subheader source (config bit 0 = 1, bit 1 = 0), stream bytes number 4 to 7 after a sync are stored in ID registers 0 to 3, and bytes 0 to 3 are not stored.
- R4: Stream bytes seen before the first sync after reset, and bytes after the last byte of the selected window, leave the ID registers and the status register unchanged.
- R5: Status bit 0 goes to 0 in the cycle after the strobe of the last byte of the selected window, and goes back to 1 in the cycle after a sync strobe.
- R6: In Q-time source (config bit 1 = 1, which overrides bit 0), a subcode strobe with index 0, 1 or 2 loads that ID register and a strobe with index 3 is ignored. ID register 3 reads 00h, sector stream bytes change no ID register, and status bit 0 only changes on a sync, which sets it to 1.
- R7: A one-cycle `xfer_done_i` pulse clears status bit 1 to 0 in the following cycle, and the flag stays 0 until it is acknowledged.
- R8: Any write to address 11h sets status bit 1 back to 1, whatever the data. If a completion pulse and an acknowledge write come in the same cycle, the bit ends at 0.
- R9: `irq_o` is 1 exactly when status bit 1 is 0 and config bit 2 (interrupt enable) is 1.
- R10: A byte strobe in the same cycle as a sync strobe is dropped, and the byte count restarts from the sync.
- R11: The config register at address 10h reads back what was written. Reads of unmapped addresses return 00h, and writes to unmapped addresses change neither the config register nor the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sync_stb_i | input | 1 | One-cycle strobe when a sector sync is detected |
| byte_stb_i | input | 1 | Sector stream byte valid |
| byte_data_i | input | 8 | Sector stream byte |
| q_stb_i | input | 1 | Subcode time byte valid |
| q_idx_i | input | 2 | Subcode time byte index (0 minute, 1 second, 2 frame) |
| q_data_i | input | 8 | Subcode time byte |
| xfer_done_i | input | 1 | One-cycle transfer completion pulse |
| wr_en_i | input | 1 | Host register write strobe |
| wr_addr_i | input | 8 | Host write address |
| wr_data_i | input | 8 | Host write data |
| rd_addr_i | input | 8 | Host read address, combinational read |
| rd_data_o | output | 8 | Host read data |
| irq_o | output | 1 | Transfer-end interrupt, active high |

## Verification
The bench builds the block with its default parameters: four ID registers, subheader window offset 4 and three Q-time bytes. With these values the byte counter saturates at 8. That brings within a short stream the bytes after the window, a sync arriving in the middle of a sector, and a Q index that names the unused fourth register. The interrupt enable is exercised both set and clear, and a completion pulse is made to collide with an acknowledge write.

// File: rtl/hdr_cap_pkg.sv
package hdr_cap_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_CFG     = 8'h10;
  localparam logic [ADDR_W-1:0] A_ACK     = 8'h11;
  localparam logic [ADDR_W-1:0] A_ID_BASE = 8'h20;
  localparam logic [ADDR_W-1:0] A_STATUS  = 8'h24;

  localparam int CFG_SUB_BIT = 0;
  localparam int CFG_QT_BIT  = 1;
  localparam int CFG_IRQ_BIT = 2;

  typedef enum logic [1:0] {
    SRC_HDR = 2'd0,
    SRC_SUB = 2'd1,
    SRC_QT  = 2'd2
  } src_e;
endpackage

// File: rtl/hdr_cap_rst_sync.sv
module hdr_cap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/hdr_cap_stream.sv
module hdr_cap_stream
  import hdr_cap_pkg::*;
#(
  parameter int NUM_ID  = 4,
  parameter int BYTE_W  = 8,
  parameter int SUB_OFS = 4,
  parameter int NUM_QT  = 3,
  localparam int IDX_W  = $clog2(NUM_ID),
  localparam int LAST   = SUB_OFS + NUM_ID,
  localparam int CNT_W  = $clog2(LAST + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  src_e                     src,
  input  logic                     sync_stb,
  input  logic                     byte_stb,
  input  logic [BYTE_W-1:0]        byte_data,
  input  logic                     q_stb,
  input  logic [IDX_W-1:0]         q_idx,
  input  logic [BYTE_W-1:0]        q_data,
  output logic [NUM_ID*BYTE_W-1:0] id_flat,
  output logic                     avail_n
);
  localparam logic [CNT_W-1:0] C_LAST = CNT_W'(LAST);
  localparam logic [CNT_W-1:0] C_NID  = CNT_W'(NUM_ID);
  localparam logic [CNT_W-1:0] C_SOFS = CNT_W'(SUB_OFS);
  localparam logic [IDX_W-1:0] I_TOP  = IDX_W'(NUM_ID - 1);
  localparam logic [IDX_W-1:0] I_NQT  = IDX_W'(NUM_QT);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cnt_en;
  logic [BYTE_W-1:0] id_q [NUM_ID];
  logic [BYTE_W-1:0] id_d [NUM_ID];
  logic              id_en;
  logic              avail_q, avail_d, avail_en;
  logic              win_hit;
  logic [CNT_W-1:0]  win_pos;
  logic [IDX_W-1:0]  win_idx;

  // window decode for the sector stream
  always_comb begin
    win_hit = 1'b0;
    win_pos = '0;
    if (byte_stb && !sync_stb && cnt_q != C_LAST) begin
      if (src == SRC_HDR && cnt_q < C_NID) begin
        win_hit = 1'b1;
        win_pos = cnt_q;
      end else if (src == SRC_SUB && cnt_q >= C_SOFS) begin
        win_hit = 1'b1;
        win_pos = cnt_q - C_SOFS;
      end
    end
    win_idx = win_pos[IDX_W-1:0];
  end

  // next state
  always_comb begin
    cnt_d   = cnt_q;
    avail_d = avail_q;
    for (int i = 0; i < NUM_ID; i++) id_d[i] = id_q[i];

    if (sync_stb) begin
      cnt_d   = '0;
      avail_d = 1'b1;
    end else if (byte_stb && cnt_q != C_LAST) begin
      cnt_d = cnt_q + 1'b1;
    end

    if (win_hit) begin
      id_d[win_idx] = byte_data;
      if (win_idx == I_TOP) avail_d = 1'b0;
    end

    if (src == SRC_QT && q_stb && q_idx < I_NQT) begin
      id_d[q_idx] = q_data;
    end
  end

  assign cnt_en   = sync_stb | byte_stb;
  assign id_en    = win_hit | (q_stb & (src == SRC_QT));
  assign avail_en = sync_stb | win_hit;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= C_LAST;
      avail_q <= 1'b1;
    end else begin
      if (cnt_en)   cnt_q   <= cnt_d;
      if (avail_en) avail_q <= avail_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ID; i++) id_q[i] <= '0;
    end else if (id_en) begin
      for (int i = 0; i < NUM_ID; i++) id_q[i] <= id_d[i];
    end
  end

  for (genvar g = 0; g < NUM_ID; g++) begin : g_flat
    assign id_flat[g*BYTE_W +: BYTE_W] = id_q[g];
  end

  assign avail_n = avail_q;
endmodule

// File: rtl/hdr_cap_flag.sv
module hdr_cap_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_pls,
  input  logic ack_wr,
  input  logic irq_en,
  output logic flag_n,
  output logic irq
);
  logic flag_q, flag_d, flag_en;

  always_comb begin
    flag_d = flag_q;
    if (set_pls)     flag_d = 1'b0;
    else if (ack_wr) flag_d = 1'b1;
  end

  assign flag_en = set_pls | ack_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b1;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_n = flag_q;
  assign irq    = ~flag_q & irq_en;
endmodule

// File: rtl/hdr_cap_regif.sv
module hdr_cap_regif
  import hdr_cap_pkg::*;
#(
  parameter int NUM_ID = 4,
  parameter int BYTE_W = 8,
  parameter int NUM_QT = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  input  logic [NUM_ID*BYTE_W-1:0] id_flat,
  input  logic                     avail_n,
  input  logic                     flag_n,
  output src_e                     src,
  output logic                     irq_en,
  output logic                     ack_wr,
  output logic [DATA_W-1:0]        rd_data
);
  logic [DATA_W-1:0] cfg_q, cfg_d;
  logic              cfg_en;

  assign cfg_en = wr_en && (wr_addr == A_CFG);
  assign cfg_d  = wr_data;
  assign ack_wr = wr_en && (wr_addr == A_ACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  always_comb begin
    if (cfg_q[CFG_QT_BIT])       src = SRC_QT;
    else if (cfg_q[CFG_SUB_BIT]) src = SRC_SUB;
    else                         src = SRC_HDR;
  end

  assign irq_en = cfg_q[CFG_IRQ_BIT];

  always_comb begin
    rd_data = '0;
    if (rd_addr == A_CFG) rd_data = cfg_q;
    if (rd_addr == A_STATUS) rd_data = {{(DATA_W-2){1'b0}}, flag_n, avail_n};
    for (int i = 0; i < NUM_ID; i++) begin
      if (rd_addr == A_ID_BASE + ADDR_W'(i)) begin
        if (src == SRC_QT && i >= NUM_QT) rd_data = '0;
        else rd_data = DATA_W'(id_flat[i*BYTE_W +: BYTE_W]);
      end
    end
  end
endmodule

// File: rtl/hdr_capture.sv
module hdr_capture
  import hdr_cap_pkg::*;
#(
  parameter int NUM_ID  = 4,
  parameter int BYTE_W  = 8,
  parameter int SUB_OFS = 4,
  parameter int NUM_QT  = 3,
  localparam int IDX_W  = $clog2(NUM_ID)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_stb_i,
  input  logic              byte_stb_i,
  input  logic [BYTE_W-1:0] byte_data_i,
  input  logic              q_stb_i,
  input  logic [IDX_W-1:0]  q_idx_i,
  input  logic [BYTE_W-1:0] q_data_i,
  input  logic              xfer_done_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  logic                     rst_sync_n;
  src_e                     src;
  logic                     irq_en;
  logic                     ack_wr;
  logic [NUM_ID*BYTE_W-1:0] id_flat;
  logic                     sect_avail_n;
  logic                     xfer_end_n;

  hdr_cap_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  hdr_cap_stream #(
    .NUM_ID (NUM_ID), .BYTE_W (BYTE_W), .SUB_OFS (SUB_OFS), .NUM_QT (NUM_QT)
  ) u_stream (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .src       (src),
    .sync_stb  (sync_stb_i),
    .byte_stb  (byte_stb_i),
    .byte_data (byte_data_i),
    .q_stb     (q_stb_i),
    .q_idx     (q_idx_i),
    .q_data    (q_data_i),
    .id_flat   (id_flat),
    .avail_n   (sect_avail_n)
  );

  hdr_cap_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_pls (xfer_done_i),
    .ack_wr  (ack_wr),
    .irq_en  (irq_en),
    .flag_n  (xfer_end_n),
    .irq     (irq_o)
  );

  hdr_cap_regif #(
    .NUM_ID (NUM_ID), .BYTE_W (BYTE_W), .NUM_QT (NUM_QT)
  ) u_regif (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en_i),
    .wr_addr (wr_addr_i),
    .wr_data (wr_data_i),
    .rd_addr (rd_addr_i),
    .id_flat (id_flat),
    .avail_n (sect_avail_n),
    .flag_n  (xfer_end_n),
    .src     (src),
    .irq_en  (irq_en),
    .ack_wr  (ack_wr),
    .rd_data (rd_data_o)
  );
endmodule

// File: rtl/hdr_capture_chk.sv
module hdr_capture_chk
  import hdr_cap_pkg::*;
#(
  parameter int NUM_ID = 4,
  parameter int BYTE_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input src_e                     src,
  input logic                     sync_stb,
  input logic                     q_stb,
  input logic                     xfer_done,
  input logic                     ack_wr,
  input logic                     irq_en,
  input logic                     flag_n,
  input logic                     avail_n,
  input logic                     irq,
  input logic [NUM_ID*BYTE_W-1:0] id_flat
);
  // R7
  xfer_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !flag_n);

  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && !xfer_done) |=> flag_n);

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (!flag_n && irq_en));

  // R5
  avail_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_stb |=> avail_n);

  // R6
  qt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_QT && !q_stb) |=> $stable(id_flat));

  // R6
  qt_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_QT && !sync_stb) |=> $stable(avail_n));
endmodule

bind hdr_capture hdr_capture_chk #(.NUM_ID(NUM_ID), .BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .src       (src),
  .sync_stb  (sync_stb_i),
  .q_stb     (q_stb_i),
  .xfer_done (xfer_done_i),
  .ack_wr    (ack_wr),
  .irq_en    (irq_en),
  .flag_n    (xfer_end_n),
  .avail_n   (sect_avail_n),
  .irq       (irq_o),
  .id_flat   (id_flat)
);

// File: tb/hdr_capture_bench.sv
module hdr_capture_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sync_stb, byte_stb, q_stb, xfer_done, wr_en;
  logic [7:0] byte_data, q_data, wr_addr, wr_data, rd_addr, rd_data;
  logic [1:0] q_idx;
  logic       irq;
  int         checks = 0;
  int         errors = 0;

  always #4 clk = ~clk;

  hdr_capture u_hdr_capture (
    .clk (clk), .rst_n (rst_n),
    .sync_stb_i (sync_stb), .byte_stb_i (byte_stb), .byte_data_i (byte_data),
    .q_stb_i (q_stb), .q_idx_i (q_idx), .q_data_i (q_data),
    .xfer_done_i (xfer_done),
    .wr_en_i (wr_en), .wr_addr_i (wr_addr), .wr_data_i (wr_data),
    .rd_addr_i (rd_addr), .rd_data_o (rd_data), .irq_o (irq)
  );

  function automatic logic [7:0] status_val(input logic avail_n, input logic xend_n);
    return {6'b0, xend_n, avail_n};
  endfunction

  function automatic int win_start(input logic sub);
    return sub ? 4 : 0;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic chk_rd(input string req, input logic [7:0] addr, input logic [7:0] exp);
    rd_addr = addr;
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic idle();
    @(negedge clk);
    sync_stb = 0; byte_stb = 0; q_stb = 0; xfer_done = 0; wr_en = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    idle();
  endtask

  task automatic sync_p();
    @(negedge clk); sync_stb = 1;
    idle();
  endtask

  task automatic sbyte(input logic [7:0] d);
    @(negedge clk); byte_stb = 1; byte_data = d;
    idle();
  endtask

  task automatic qbyte(input logic [1:0] i, input logic [7:0] d);
    @(negedge clk); q_stb = 1; q_idx = i; q_data = d;
    idle();
  endtask

  task automatic done_p();
    @(negedge clk); xfer_done = 1;
    idle();
  endtask

  task automatic chk_ids(input string req, input logic [7:0] e0, e1, e2, e3);
    chk_rd(req, 8'h20, e0); chk_rd(req, 8'h21, e1);
    chk_rd(req, 8'h22, e2); chk_rd(req, 8'h23, e3);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] sec [12];
    void'($urandom(32'h5EC7_0A11));
    sync_stb = 0; byte_stb = 0; q_stb = 0; xfer_done = 0; wr_en = 0;
    byte_data = 0; q_data = 0; q_idx = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk_ids("R1", 8'h00, 8'h00, 8'h00, 8'h00);
    chk_rd("R1", 8'h24, 8'h03);
    chk_rd("R1", 8'h10, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    // R11 unmapped read
    chk_rd("R11", 8'h55, 8'h00);

    // R4 bytes before first sync
    for (int i = 0; i < 8; i++) sbyte(8'hE0 + 8'(i));
    chk_ids("R4 pre-sync", 8'h00, 8'h00, 8'h00, 8'h00);
    chk_rd("R4 pre-sync", 8'h24, 8'h03);

    // R2 header source, R5 flag timing
    sync_p();
    for (int i = 0; i < 3; i++) sbyte(8'hA0 + 8'(i));
    chk_rd("R5 not yet", 8'h24, 8'h03);
    sbyte(8'hA3);
    chk_rd("R5 after last", 8'h24, 8'h02);
    chk_ids("R2", 8'hA0, 8'hA1, 8'hA2, 8'hA3);
    for (int i = 4; i < 11; i++) sbyte(8'hA0 + 8'(i));
    chk_ids("R4 past window", 8'hA0, 8'hA1, 8'hA2, 8'hA3);
    chk_rd("R4 past window", 8'h24, 8'h02);
    sync_p();
    chk_rd("R5 sync", 8'h24, 8'h03);

    // R3 subheader source
    wr(8'h10, 8'h01);
    chk_rd("R11 cfg", 8'h10, 8'h01);
    for (int i = 0; i < 4; i++) sbyte(8'hB0 + 8'(i));
    chk_ids("R3 header bytes skipped", 8'hA0, 8'hA1, 8'hA2, 8'hA3);
    chk_rd("R3 no avail yet", 8'h24, 8'h03);
    for (int i = 4; i < 8; i++) sbyte(8'hB0 + 8'(i));
    chk_ids("R3", 8'hB4, 8'hB5, 8'hB6, 8'hB7);
    chk_rd("R5 sub", 8'h24, 8'h02);

    // R10 sync and byte in the same cycle
    wr(8'h10, 8'h00);
    @(negedge clk); sync_stb = 1; byte_stb = 1; byte_data = 8'hCC;
    idle();
    for (int i = 1; i < 5; i++) sbyte(8'hC0 + 8'(i));
    chk_ids("R10", 8'hC1, 8'hC2, 8'hC3, 8'hC4);

    // R6 Q-time source
    wr(8'h10, 8'h03);
    qbyte(2'd0, 8'h12); qbyte(2'd1, 8'h34); qbyte(2'd2, 8'h56); qbyte(2'd3, 8'h78);
    chk_ids("R6", 8'h12, 8'h34, 8'h56, 8'h00);
    sync_p();
    chk_rd("R6 sync", 8'h24, 8'h03);
    for (int i = 0; i < 8; i++) sbyte(8'hD0 + 8'(i));
    chk_ids("R6 stream ignored", 8'h12, 8'h34, 8'h56, 8'h00);
    chk_rd("R6 avail stays", 8'h24, 8'h03);
    wr(8'h10, 8'h00);
    chk_rd("R6 reg3 untouched", 8'h23, 8'hC4);

    // R7 R8 R9 transfer-end flag
    wr(8'h10, 8'h04);
    done_p();
    chk_rd("R7", 8'h24, status_val(1'b1, 1'b0));
    chk("R9 enabled", {7'b0, irq}, 8'h01);
    repeat (3) idle();
    chk_rd("R7 holds", 8'h24, 8'h01);
    wr(8'h33, 8'h00);
    chk_rd("R11 unmapped write", 8'h24, 8'h01);
    chk_rd("R11 unmapped write cfg", 8'h10, 8'h04);
    wr(8'h11, 8'h5A);
    chk_rd("R8", 8'h24, 8'h03);
    chk("R9 cleared", {7'b0, irq}, 8'h00);
    wr(8'h10, 8'h00);
    done_p();
    chk("R9 disabled", {7'b0, irq}, 8'h00);
    wr(8'h11, 8'h00);
    @(negedge clk); xfer_done = 1; wr_en = 1; wr_addr = 8'h11; wr_data = 8'hFF;
    idle();
    chk_rd("R8 set wins", 8'h24, 8'h01);
    wr(8'h11, 8'hA5);
    chk_rd("R8 any data", 8'h24, 8'h03);

    // R2 R3 R5 random sectors
    for (int s = 0; s < 40; s++) begin
      logic sub;
      int   n, st;
      sub = 1'($urandom % 2);
      n   = 8 + int'($urandom % 5);
      st  = win_start(sub);
      wr(8'h10, {7'b0, sub});
      sync_p();
      chk_rd("R5 rand sync", 8'h24, 8'h03);
      for (int i = 0; i < n; i++) begin
        sec[i] = 8'($urandom);
        repeat ($urandom % 3) idle();
        sbyte(sec[i]);
      end
      chk_ids(sub ? "R3 rand" : "R2 rand", sec[st], sec[st+1], sec[st+2], sec[st+3]);
      chk_rd("R5 rand", 8'h24, 8'h02);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule